// File: doc/BRIEF.md
# UART Receive Error Status Tracker

This block gathers the per-character error events produced by a UART receiver and its receive FIFO into one byte-wide status word that a host reads through a simple register interface. Four error kinds are tracked:

- a detected break;
- a character that ended without its stop bit;
- a parity mismatch;
- a byte that finished arriving while the FIFO was already full.

Each error kind is kept as a sticky flag. A flag stays set until the host reads the status word. One more bit is not sticky: it shows whether the line is in break right now.

A read is signalled by a one-cycle read strobe. During the strobe cycle, the status output carries the flag values that the host captures. The clear takes effect at the next clock edge. If a new event for a flag arrives in the same cycle as the read, that flag stays set, so the event is seen on the next read.

The overrun event carries no data. The block records only the flag and has no path that could touch FIFO contents.

Reset is an asynchronous active-low input. Inside the block it is released in step with the clock.

Top module: `rxerr_status`

## Requirements
- R1: After reset, all eight bits of `status_o` read 0.
- R2: Bits 2, 1 and 0 of `status_o` are always 0.
- R3: A pulse on `evt_break` sets bit 3 of `status_o` from the next clock edge. The bit stays 1 until it is cleared by a read.
- R4: A pulse on `evt_frame` (a stop bit was missing) sets bit 4 from the next clock edge. The bit stays 1 until it is cleared by a read.
- R5: A pulse on `evt_parity` sets bit 5 from the next clock edge. The bit stays 1 until it is cleared by a read.
- R6: A pulse on `evt_ovfl` (a byte arrived while the FIFO was full) sets bit 6 from the next clock edge. The bit stays 1 until it is cleared by a read. No data is recorded with it.
- R7: Bit 7 of `status_o` is not sticky. It equals the value of `brk_level` sampled at the previous clock edge.
- R8: While `rd_stb` is high, `status_o` shows the current flag values. At the following edge, each sticky flag with no event in that cycle clears to 0.
- R9: If a flag's event is high in the same cycle as `rd_stb`, that flag is 1 after the edge.
- R10: A flag with neither an event nor a read in a cycle keeps its value. Each flag is independent of the events for the other flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_break | input | 1 | Pulse: a break was detected |
| evt_frame | input | 1 | Pulse: a character ended without a stop bit |
| evt_parity | input | 1 | Pulse: a parity mismatch |
| evt_ovfl | input | 1 | Pulse: a byte arrived while the FIFO was full |
| brk_level | input | 1 | Level: the line is currently in break |
| rd_stb | input | 1 | One-cycle status read strobe |
| status_o | output | 8 | Status word: {live break, overrun, parity, framing, break, 3'b000} |

## Verification
The assertions check the per-flag rules on every cycle:

- an event sets its flag;
- a read without an event clears the flag;
- with no event and no read the flag holds;
- the reserved bits stay zero;
- the live bit follows the break level one cycle late.

Some behaviour is visible only in the bench's scenarios:

- the value the host captures during the strobe cycle;
- the read and event collision across a full read sequence;
- the independence of the four flags under many mixed input patterns.

The bench sweeps a long pseudo-random run of every input combination against an arithmetic model.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  // Count of sticky error kinds and count of reserved low bits
  localparam int NUM_ERR  = 4;
  localparam int RSVD_W   = 3;
  // Derived layout of the status word
  localparam int ERR_LSB  = RSVD_W;
  localparam int LIVE_BIT = RSVD_W + NUM_ERR;
  localparam int STATUS_W = RSVD_W + NUM_ERR + 1;
  // Index of each error kind inside the sticky bank
  localparam int IDX_BREAK  = 0;
  localparam int IDX_FRAME  = 1;
  localparam int IDX_PARITY = 2;
  localparam int IDX_OVFL   = 3;
endpackage

// File: rtl/rxerr_rst_sync.sv
module rxerr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rxerr_sticky_bank.sv
module rxerr_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         rd_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic         upd_en;

  // A new event takes priority over the read clear
  for (genvar gi = 0; gi < N; gi++) begin : g_flag
    assign flag_d[gi] = evt_i[gi] | (flag_q[gi] & ~rd_i);

    // R3 R4 R5 R6: an event sets this flag at the next edge
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[gi] |=> flag_q[gi]);

    // R8: a read without an event clears this flag
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !evt_i[gi]) |=> !flag_q[gi]);

    // R10: with no event and no read, this flag holds its value
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && !evt_i[gi]) |=> $stable(flag_q[gi]));
  end

  assign upd_en = rd_i | (|evt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (upd_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rxerr_break_live.sv
module rxerr_break_live (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_i,
  output logic live_o
);
  logic live_q;
  logic live_d;
  logic live_en;

  assign live_d  = brk_i;
  assign live_en = live_q ^ brk_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else if (live_en) begin
      live_q <= live_d;
    end
  end

  assign live_o = live_q;
endmodule

// File: rtl/rxerr_status.sv
module rxerr_status
  import rxerr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_break,
  input  logic                evt_frame,
  input  logic                evt_parity,
  input  logic                evt_ovfl,
  input  logic                brk_level,
  input  logic                rd_stb,
  output logic [STATUS_W-1:0] status_o
);
  logic               rst_n_int;
  logic [NUM_ERR-1:0] evt_vec;
  logic [NUM_ERR-1:0] flags;
  logic               live_brk;

  always_comb begin
    evt_vec             = '0;
    evt_vec[IDX_BREAK]  = evt_break;
    evt_vec[IDX_FRAME]  = evt_frame;
    evt_vec[IDX_PARITY] = evt_parity;
    evt_vec[IDX_OVFL]   = evt_ovfl;
  end

  rxerr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rxerr_sticky_bank #(.N(NUM_ERR)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .evt_i  (evt_vec),
    .rd_i   (rd_stb),
    .flag_o (flags)
  );

  rxerr_break_live u_live (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .brk_i  (brk_level),
    .live_o (live_brk)
  );

  always_comb begin
    status_o                          = '0;
    status_o[ERR_LSB +: NUM_ERR]      = flags;
    status_o[LIVE_BIT]                = live_brk;
  end

  // R2
  always_comb begin
    rsvd_zero_chk: assert (status_o[RSVD_W-1:0] == '0);
  end

  // R7
  live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    brk_level |=> status_o[LIVE_BIT]);

  // R7
  live_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !brk_level |=> !status_o[LIVE_BIT]);

  // R9
  collide_set_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_stb && evt_parity) |=> status_o[ERR_LSB + IDX_PARITY]);
endmodule

// File: tb/tb_rxerr_status.sv
module tb_rxerr_status;
  localparam int CLK_PERIOD = 10;
  localparam int SWEEP_N    = 4096;
  localparam int WDOG_CYC   = 20000;

  logic       clk;
  logic       rst_n;
  logic [3:0] evt;
  logic       rd;
  logic       brk;
  logic [7:0] status_o;

  int n_vec;
  int n_bad;
  logic [3:0] m_flags;
  logic       m_live;

  rxerr_status dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_break  (evt[0]),
    .evt_frame  (evt[1]),
    .evt_parity (evt[2]),
    .evt_ovfl   (evt[3]),
    .brk_level  (brk),
    .rd_stb     (rd),
    .status_o   (status_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_word();
    return {m_live, m_flags, 3'b000};
  endfunction

  task automatic check(input logic [7:0] exp, input string tag);
    n_vec++;
    if (status_o !== exp) begin
      n_bad++;
      $display("FAIL %s: status_o=%h expected=%h", tag, status_o, exp);
    end
  endtask

  // Called at a negedge: drive, check read data, clock, update model, check
  task automatic apply(input logic [3:0] e, input logic r, input logic b, input string tag);
    evt = e; rd = r; brk = b;
    #1;
    if (r) check(model_word(), {tag, " R8 read data during strobe"});
    @(posedge clk);
    m_flags = e | (m_flags & ~{4{r}});
    m_live  = b;
    @(negedge clk);
    check(model_word(), tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: cycles=%0d expected<%0d", WDOG_CYC, WDOG_CYC);
    summary();
  end

  initial begin
    logic [31:0] lcg;
    n_vec = 0; n_bad = 0;
    evt = '0; rd = 1'b0; brk = 1'b0; rst_n = 1'b0;
    m_flags = '0; m_live = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(8'h00, "R1 reset state");

    // Each flag set alone, held, then read away: R3 R4 R5 R6 R10
    for (int k = 0; k < 4; k++) begin
      apply(4'(1 << k), 1'b0, 1'b0, "R3 R4 R5 R6 single event set");
      apply(4'h0, 1'b0, 1'b0, "R10 hold without read");
      apply(4'h0, 1'b1, 1'b0, "R8 clear after read");
    end

    // Read data and clear: R8
    apply(4'b0100, 1'b0, 1'b0, "R5 parity set");
    apply(4'b0000, 1'b1, 1'b0, "R8 read clears parity");
    if (status_o[5] !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: bit5=%b expected=0", status_o[5]);
    end
    n_vec++;

    // Collision: R9
    apply(4'b0010, 1'b0, 1'b0, "R4 framing set");
    apply(4'b0010, 1'b1, 1'b0, "R9 event during read keeps flag");
    apply(4'b0000, 1'b1, 1'b0, "R9 next read clears");

    // Live break: R7, not sticky
    apply(4'b0001, 1'b0, 1'b1, "R7 break live on");
    apply(4'b0000, 1'b0, 1'b1, "R7 break live held");
    apply(4'b0000, 1'b0, 1'b0, "R7 break live off");
    apply(4'b0000, 1'b1, 1'b0, "R3 break flag read");

    // Overrun recorded as a flag only: R6
    apply(4'b1000, 1'b0, 1'b0, "R6 overrun set");
    apply(4'b1000, 1'b0, 1'b0, "R6 overrun repeat");
    apply(4'b0000, 1'b1, 1'b0, "R6 overrun read");

    // Sweep of mixed patterns: R2 R3 R4 R5 R6 R7 R8 R9 R10
    lcg = 32'h1234_5678;
    for (int i = 0; i < SWEEP_N; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      apply(lcg[19:16] & lcg[23:20], lcg[26] & lcg[27], lcg[29],
            "R2 R3 R4 R5 R6 R7 R8 R9 R10 sweep");
    end

    // Reset mid-run: R1
    apply(4'hF, 1'b0, 1'b1, "R1 preload");
    rst_n = 1'b0;
    #1;
    check(8'h00, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    m_flags = '0; m_live = 1'b0;
    evt = '0; brk = 1'b0;
    repeat (3) @(negedge clk);
    check(8'h00, "R1 after release");

    summary();
  end
endmodule